// File: doc/BRIEF.md
# Low-Power Mode Controller

This block sequences an 8-bit microcontroller core between three operating states: normal run, idle and power-down. Software raises a one-cycle request for idle or for power-down. The block then gates the CPU clock, the peripheral clock and the oscillator enable to match the state it enters. Enabled interrupt requests arrive already masked, as one bit per source. They pull the core out of idle. Power-down ignores interrupts and ends only through a qualified hardware reset.

The raw reset pin is filtered by a counter that runs on a free-running reference clock, so reset still works after the main oscillator has been gated off. The same counter is the only exit from power-down. The block also drives hold controls for the address-latch strobe and the program-read strobe, and mode controls for the two bus ports. These controls depend on the state and on whether code is fetched from external program memory. Register and RAM contents are kept outside the block.

Top module: `lowpwr_ctrl`

## Requirements
- R1: After the power-on reset `arst_n` is released, the state is run (`mode` = 2'b00), all three clock enables are 1, `core_rst` is 0 and every pin override output is 0.
- R2: `core_rst` goes to 1 on the clock edge that samples `rst_pin` high for the 24th time in a row (two 12-clock machine cycles). Any low sample restarts the count, and `core_rst` returns to 0 on the first edge that samples `rst_pin` low.
- R3: While `core_rst` is 1, the state is forced to run on the next edge, and idle and power-down requests have no effect.
- R4: In idle (`mode` = 2'b01), `cpu_clk_en` is 0 while `per_clk_en` and `osc_en` stay 1.
- R5: In power-down (`mode` = 2'b10), `cpu_clk_en`, `per_clk_en` and `osc_en` are all 0. Interrupts are ignored. The state returns to run one edge after `core_rst` rises.
- R6: When `idle_req` and `pdown_req` are both high in the same run cycle, power-down is entered.
- R7: In idle, `ale_ovr`, `ale_val`, `psen_ovr` and `psen_val` are all 1, so both strobes are held high.
- R8: In power-down, `ale_ovr` and `psen_ovr` are 1 and `ale_val` and `psen_val` are 0, so both strobes are held low.
- R9: With `ext_code` = 1, `p0_float` is 1 in both idle and power-down. `p2_addr_sel` is 1 in idle only, so port 2 carries the address in idle and its latch data in power-down.
- R10: With `ext_code` = 0, `p0_float` and `p2_addr_sel` are 0 in every state, so all ports keep their latch data.
- R11: Any nonzero `irq_vec` in idle returns the state to run, with `cpu_clk_en` = 1, on the next clock edge. In idle, further idle or power-down requests have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| arst_n | input | 1 | Asynchronous power-on reset, active low |
| rst_pin | input | 1 | Raw hardware reset pin, synchronous to clk |
| idle_req | input | 1 | One-cycle software request to enter idle |
| pdown_req | input | 1 | One-cycle software request to enter power-down |
| irq_vec | input | IRQ_W | Enabled interrupt requests, one bit per source |
| ext_code | input | 1 | 1 when code executes from external program memory |
| core_rst | output | 1 | Qualified internal reset |
| mode | output | 2 | State: 00 run, 01 idle, 10 power-down |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Timer, serial and interrupt logic clock enable |
| osc_en | output | 1 | Main oscillator enable |
| ale_ovr | output | 1 | Address-latch strobe held by this block |
| ale_val | output | 1 | Level of the held address-latch strobe |
| psen_ovr | output | 1 | Program-read strobe held by this block |
| psen_val | output | 1 | Level of the held program-read strobe |
| p0_float | output | 1 | Port 0 drivers released to high impedance |
| p2_addr_sel | output | 1 | Port 2 drives the address instead of its latch |

## Verification
A request or an interrupt sampled on one edge changes `mode`, the clock enables and the pin controls on that same edge, because they are decoded from one state register. The bench drives each stimulus on a falling edge and checks the outputs on the next falling edge. `core_rst` is due on the 24th consecutive high sample and the exit from power-down one edge later, so the bench counts rising edges exactly and checks one edge before each transition and again on the transition edge. The bench also checks that a pattern of 23 highs, or a count broken by one low sample, does not assert `core_rst`.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
   typedef enum logic [1:0] {
      MODE_RUN   = 2'b00,
      MODE_IDLE  = 2'b01,
      MODE_PDOWN = 2'b10
   } lpm_mode_e;
endpackage

// File: rtl/lpm_rst_qual.sv
module lpm_rst_qual #(
   parameter int CLK_PER_MC = 12,
   parameter int RST_MC     = 2
) (
   input  logic clk,
   input  logic arst_n,
   input  logic rst_pin_i,
   output logic core_rst_o
);
   localparam int LIMIT = CLK_PER_MC * RST_MC;
   localparam int CNT_W = $clog2(LIMIT + 1);
   localparam logic [CNT_W-1:0] LIM_C  = CNT_W'(LIMIT);
   localparam logic [CNT_W-1:0] LIM_M1 = CNT_W'(LIMIT - 1);

   if (CLK_PER_MC < 1) begin : g_bad_mc
      $error("CLK_PER_MC must be at least 1");
   end
   if (RST_MC < 1) begin : g_bad_rmc
      $error("RST_MC must be at least 1");
   end

   logic [CNT_W-1:0] cnt_q;
   logic             rst_q;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         cnt_q <= '0;
         rst_q <= 1'b0;
      end else if (rst_pin_i) begin
         if (cnt_q != LIM_C) cnt_q <= cnt_q + 1'b1;
         rst_q <= (cnt_q >= LIM_M1);
      end else begin
         cnt_q <= '0;
         rst_q <= 1'b0;
      end
   end

   assign core_rst_o = rst_q;

   assert_low_clears_R2: assert property (@(posedge clk) disable iff (!arst_n)
      !rst_pin_i |=> !core_rst_o);
   assert_rise_needs_pin_R2: assert property (@(posedge clk) disable iff (!arst_n)
      $rose(core_rst_o) |-> $past(rst_pin_i));
endmodule

// File: rtl/lpm_mode_fsm.sv
module lpm_mode_fsm
   import lpm_pkg::*;
#(
   parameter int IRQ_W = 5
) (
   input  logic             clk,
   input  logic             arst_n,
   input  logic             core_rst_i,
   input  logic             idle_req_i,
   input  logic             pdown_req_i,
   input  logic [IRQ_W-1:0] irq_i,
   output lpm_mode_e        mode_o
);
   if (IRQ_W < 1) begin : g_bad_irq
      $error("IRQ_W must be at least 1");
   end

   lpm_mode_e mode_q, mode_d;
   logic      wake;

   assign wake = |irq_i;

   always_comb begin
      mode_d = mode_q;
      if (core_rst_i) begin
         mode_d = MODE_RUN;
      end else begin
         unique case (mode_q)
            MODE_RUN: begin
               if (pdown_req_i)     mode_d = MODE_PDOWN;
               else if (idle_req_i) mode_d = MODE_IDLE;
            end
            MODE_IDLE:  if (wake) mode_d = MODE_RUN;
            MODE_PDOWN: mode_d = MODE_PDOWN;
            default:    mode_d = MODE_RUN;
         endcase
      end
   end

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) mode_q <= MODE_RUN;
      else         mode_q <= mode_d;
   end

   assign mode_o = mode_q;

   assert_reset_forces_run_R3: assert property (@(posedge clk) disable iff (!arst_n)
      core_rst_i |=> (mode_o == MODE_RUN));
   assert_idle_wake_R11: assert property (@(posedge clk) disable iff (!arst_n)
      (mode_o == MODE_IDLE && wake && !core_rst_i) |=> (mode_o == MODE_RUN));
   assert_idle_sticky_R11: assert property (@(posedge clk) disable iff (!arst_n)
      (mode_o == MODE_IDLE && !wake && !core_rst_i) |=> (mode_o == MODE_IDLE));
   assert_pdown_hold_R5: assert property (@(posedge clk) disable iff (!arst_n)
      (mode_o == MODE_PDOWN && !core_rst_i) |=> (mode_o == MODE_PDOWN));
   assert_pdown_wins_R6: assert property (@(posedge clk) disable iff (!arst_n)
      (mode_o == MODE_RUN && idle_req_i && pdown_req_i && !core_rst_i)
      |=> (mode_o == MODE_PDOWN));
endmodule

// File: rtl/lpm_pin_ctrl.sv
module lpm_pin_ctrl
   import lpm_pkg::*;
#(
   parameter bit OUT_REG = 1'b0
) (
   input  logic      clk,
   input  logic      arst_n,
   input  lpm_mode_e mode_i,
   input  logic      ext_code_i,
   output logic      ale_ovr_o,
   output logic      ale_val_o,
   output logic      psen_ovr_o,
   output logic      psen_val_o,
   output logic      p0_float_o,
   output logic      p2_addr_o
);
   typedef struct packed {
      logic ale_ovr;
      logic ale_val;
      logic psen_ovr;
      logic psen_val;
      logic p0_float;
      logic p2_addr;
   } pin_ctl_t;

   pin_ctl_t nxt, outp;
   logic     low_pwr;

   always_comb begin
      low_pwr      = (mode_i != MODE_RUN);
      nxt.ale_ovr  = low_pwr;
      nxt.psen_ovr = low_pwr;
      nxt.ale_val  = (mode_i == MODE_IDLE);
      nxt.psen_val = (mode_i == MODE_IDLE);
      nxt.p0_float = low_pwr && ext_code_i;
      nxt.p2_addr  = (mode_i == MODE_IDLE) && ext_code_i;
   end

   if (OUT_REG) begin : g_reg
      pin_ctl_t q;
      always_ff @(posedge clk or negedge arst_n) begin
         if (!arst_n) q <= '0;
         else         q <= nxt;
      end
      assign outp = q;
   end else begin : g_comb
      assign outp = nxt;
   end

   assign ale_ovr_o  = outp.ale_ovr;
   assign ale_val_o  = outp.ale_val;
   assign psen_ovr_o = outp.psen_ovr;
   assign psen_val_o = outp.psen_val;
   assign p0_float_o = outp.p0_float;
   assign p2_addr_o  = outp.p2_addr;

   assert_p2_addr_implies_float_R9: assert property (@(posedge clk) disable iff (!arst_n)
      p2_addr_o |-> (p0_float_o && ale_ovr_o && ale_val_o));
   assert_float_only_held_R10: assert property (@(posedge clk) disable iff (!arst_n)
      p0_float_o |-> (ale_ovr_o && psen_ovr_o));
endmodule

// File: rtl/lowpwr_ctrl.sv
module lowpwr_ctrl
   import lpm_pkg::*;
#(
   parameter int IRQ_W      = 5,
   parameter int CLK_PER_MC = 12,
   parameter int RST_MC     = 2,
   parameter bit OUT_REG    = 1'b0
) (
   input  logic             clk,
   input  logic             arst_n,
   input  logic             rst_pin,
   input  logic             idle_req,
   input  logic             pdown_req,
   input  logic [IRQ_W-1:0] irq_vec,
   input  logic             ext_code,
   output logic             core_rst,
   output logic [1:0]       mode,
   output logic             cpu_clk_en,
   output logic             per_clk_en,
   output logic             osc_en,
   output logic             ale_ovr,
   output logic             ale_val,
   output logic             psen_ovr,
   output logic             psen_val,
   output logic             p0_float,
   output logic             p2_addr_sel
);
   lpm_mode_e mode_s;
   logic      rst_s;

   lpm_rst_qual #(.CLK_PER_MC(CLK_PER_MC), .RST_MC(RST_MC)) u_qual (
      .clk(clk), .arst_n(arst_n), .rst_pin_i(rst_pin), .core_rst_o(rst_s)
   );

   lpm_mode_fsm #(.IRQ_W(IRQ_W)) u_fsm (
      .clk(clk), .arst_n(arst_n), .core_rst_i(rst_s),
      .idle_req_i(idle_req), .pdown_req_i(pdown_req),
      .irq_i(irq_vec), .mode_o(mode_s)
   );

   lpm_pin_ctrl #(.OUT_REG(OUT_REG)) u_pins (
      .clk(clk), .arst_n(arst_n), .mode_i(mode_s), .ext_code_i(ext_code),
      .ale_ovr_o(ale_ovr), .ale_val_o(ale_val),
      .psen_ovr_o(psen_ovr), .psen_val_o(psen_val),
      .p0_float_o(p0_float), .p2_addr_o(p2_addr_sel)
   );

   always_comb begin
      cpu_clk_en = (mode_s == MODE_RUN);
      per_clk_en = (mode_s != MODE_PDOWN);
      osc_en     = (mode_s != MODE_PDOWN);
   end

   assign core_rst = rst_s;
   assign mode     = mode_s;

   assert_osc_off_needs_req_R5: assert property (@(posedge clk) disable iff (!arst_n)
      $fell(osc_en) |-> $past(pdown_req));
   assert_cpu_on_after_wake_R11: assert property (@(posedge clk) disable iff (!arst_n)
      $rose(cpu_clk_en) |-> ($past(|irq_vec) || $past(core_rst)));
endmodule

// File: tb/lowpwr_ctrl_tb.sv
module lowpwr_ctrl_tb;
   localparam int IRQ_W = 5;

   logic clk = 1'b0;
   logic arst_n, rst_pin, idle_req, pdown_req, ext_code;
   logic [IRQ_W-1:0] irq_vec;
   logic core_rst, cpu_clk_en, per_clk_en, osc_en;
   logic ale_ovr, ale_val, psen_ovr, psen_val, p0_float, p2_addr_sel;
   logic [1:0] mode;
   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   lowpwr_ctrl #(.IRQ_W(IRQ_W)) u_dut (
      .clk(clk), .arst_n(arst_n), .rst_pin(rst_pin), .idle_req(idle_req),
      .pdown_req(pdown_req), .irq_vec(irq_vec), .ext_code(ext_code),
      .core_rst(core_rst), .mode(mode), .cpu_clk_en(cpu_clk_en),
      .per_clk_en(per_clk_en), .osc_en(osc_en), .ale_ovr(ale_ovr),
      .ale_val(ale_val), .psen_ovr(psen_ovr), .psen_val(psen_val),
      .p0_float(p0_float), .p2_addr_sel(p2_addr_sel)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // clocks {cpu,per,osc}; pins {ale_ovr,ale_val,psen_ovr,psen_val,p0_float,p2_addr_sel}
   task automatic chk_state(input string req, input logic [1:0] m, input logic [2:0] clks,
                            input logic [5:0] pins);
      chk({req, " mode"}, 32'(mode), 32'(m));
      chk({req, " clock enables"}, 32'({cpu_clk_en, per_clk_en, osc_en}), 32'(clks));
      chk({req, " pin controls"},
          32'({ale_ovr, ale_val, psen_ovr, psen_val, p0_float, p2_addr_sel}), 32'(pins));
   endtask

   task automatic pulse_req(input logic i_r, input logic p_r);
      @(negedge clk);
      idle_req = i_r; pdown_req = p_r;
      @(negedge clk);
      idle_req = 1'b0; pdown_req = 1'b0;
   endtask

   // holds rst_pin high for n rising edges, sampling from the next edge on
   task automatic hold_pin(input int n);
      @(negedge clk);
      rst_pin = 1'b1;
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic release_pin();
      rst_pin = 1'b0;
      @(negedge clk);
      chk("R2 release", 32'(core_rst), 32'd0);
   endtask

   task automatic t_reset_state();
      chk_state("R1 reset", 2'b00, 3'b111, 6'b000000);
      chk("R1 core_rst", 32'(core_rst), 32'd0);
   endtask

   task automatic t_idle(input logic ext);
      ext_code = ext;
      pulse_req(1'b1, 1'b0);
      if (ext) chk_state("R4 R7 R9 idle ext", 2'b01, 3'b011, 6'b111111);
      else     chk_state("R4 R7 R10 idle int", 2'b01, 3'b011, 6'b111100);
      repeat (3) @(negedge clk);
      chk("R11 idle holds", 32'(mode), 32'd1);
      pulse_req(1'b0, 1'b1);
      chk("R11 pdown req ignored in idle", 32'(mode), 32'd1);
      pulse_req(1'b1, 1'b1);
      chk("R11 both req ignored in idle", 32'(mode), 32'd1);
      irq_vec = 5'b01000;
      @(negedge clk);
      irq_vec = '0;
      chk_state("R11 wake", 2'b00, 3'b111, 6'b000000);
   endtask

   task automatic t_pdown(input logic ext, input logic both);
      ext_code = ext;
      pulse_req(both, 1'b1);
      if (ext) chk_state(both ? "R6 R8 R9 pdown ext" : "R5 R8 R9 pdown ext",
                         2'b10, 3'b000, 6'b101010);
      else     chk_state(both ? "R6 R8 R10 pdown int" : "R5 R8 R10 pdown int",
                         2'b10, 3'b000, 6'b101000);
      irq_vec = '1;
      repeat (4) @(negedge clk);
      irq_vec = '0;
      chk("R5 irq ignored in pdown", 32'(mode), 32'd2);
      chk("R5 osc stays off", 32'(osc_en), 32'd0);
      hold_pin(24);
      chk("R2 core_rst in pdown", 32'(core_rst), 32'd1);
      chk("R5 one edge lag", 32'(mode), 32'd2);
      @(negedge clk);
      chk_state("R5 exit by reset", 2'b00, 3'b111, 6'b000000);
      release_pin();
   endtask

   task automatic t_qualifier();
      hold_pin(23);
      chk("R2 23 highs", 32'(core_rst), 32'd0);
      @(negedge clk);
      chk("R2 24 highs", 32'(core_rst), 32'd1);
      release_pin();
      hold_pin(12);
      rst_pin = 1'b0;
      @(negedge clk);
      hold_pin(23);
      chk("R2 count restarts after low", 32'(core_rst), 32'd0);
      @(negedge clk);
      chk("R2 restarted count completes", 32'(core_rst), 32'd1);
      // R3: requests while qualified reset is held
      idle_req = 1'b1;
      @(negedge clk);
      idle_req = 1'b0; pdown_req = 1'b1;
      @(negedge clk);
      pdown_req = 1'b0;
      @(negedge clk);
      chk("R3 requests ignored in reset", 32'(mode), 32'd0);
      chk("R3 clocks on in reset", 32'({cpu_clk_en, per_clk_en, osc_en}), 32'd7);
      release_pin();
   endtask

   task automatic t_run_pins_ext();
      ext_code = 1'b1;
      @(negedge clk);
      chk_state("R10 run ext no override", 2'b00, 3'b111, 6'b000000);
      ext_code = 1'b0;
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      arst_n = 1'b0; rst_pin = 1'b0; idle_req = 1'b0; pdown_req = 1'b0;
      ext_code = 1'b0; irq_vec = '0;
      repeat (3) @(negedge clk);
      arst_n = 1'b1;
      @(negedge clk);
      t_reset_state();
      t_run_pins_ext();
      t_idle(1'b0);
      t_idle(1'b1);
      t_pdown(1'b1, 1'b0);
      t_pdown(1'b0, 1'b1);
      t_qualifier();
      t_idle(1'b1);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule